// File: doc/BRIEF.md
# Timer Capture/Compare Channel with Preloaded Compare Value

This block is a single capture/compare channel of a general-purpose timer. It takes a counter value from a timer core outside the block and a configuration word written through a simple register-style write strobe. In compare mode it holds a compare value and drives a pulse-width style output that is high while the counter is below that value. The polarity bit can invert this output.

The compare value is double-buffered. Software writes always land in a software-visible value register. Each write carries a preload bit. When the bit is clear, the write also reaches the active compare register at once. When it is set, the active register is refreshed from the value register only on an update event from the timer core. In capture mode the same value register instead latches the counter value on each rising edge of an asynchronous trigger input. The trigger is synchronised through two flops before edge detection.

Top module: `tmr_cc_channel`

## Requirements
- R1: After a synchronous reset, every configuration bit and both value registers are 0, `reg_rdata` reads 0 and `ch_out` is 0.
- R2: A write with `reg_wr` high stores the word `reg_wdata`, laid out as value in bits [15:0], enable in bit 16, preload in bit 17, polarity in bit 18 and mode in bit 19 (0 = compare, 1 = capture). `reg_rdata` returns the stored configuration and value register in the same layout from the cycle after the write.
- R3: A written value above 100 is stored as 100. Values from 0 to 100 are stored unchanged. The active compare register never holds a value above 100.
- R4: A write whose preload bit is 0 loads the active compare register at the same clock edge as the value register, so `ch_out` reflects the new value in the following cycle.
- R5: While the stored preload bit is 1, a write changes only the value register. The active register is unchanged until a cycle with `update_evt` high copies the value register into it.
- R6: When a write with preload bit 1 and `update_evt` fall on the same cycle while the stored preload bit is 1, the active register receives the value register's previous contents. The newly written value reaches the active register at the next update event.
- R7: When the channel is enabled in compare mode, `ch_out` equals (`counter` < active value) XOR polarity.
- R8: When the channel is disabled, or is in capture mode, `ch_out` is 0.
- R9: When the channel is enabled in capture mode, a rising edge on `trig_in` stores the counter value in the value register at the third clock edge after the edge is set up. A trigger held high does not capture again. While the channel is disabled, trigger edges leave the value register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe for the configuration word |
| reg_wdata | input | 20 | Written word: value, enable, preload, polarity, mode |
| reg_rdata | output | 20 | Read-back of configuration and value register |
| counter | input | 16 | Timer counter value from the timer core |
| update_evt | input | 1 | Update event pulse from the timer core |
| trig_in | input | 1 | Asynchronous capture trigger |
| ch_out | output | 1 | Compare output |

## Verification
On every cycle, the assertions check three things. The active register stays within range. It holds when there is neither a write nor an update. Immediate writes and same-cycle write/update collisions load the expected value. The assertions also check that a disabled or capturing channel keeps its output low, that a detected trigger edge lasts a single cycle, and that a capture stores the counter. Only the bench scenarios can show the end-to-end effects at the ports. These are the threshold position of the output for several compare values and both polarities, the delayed effect of preloaded writes, the synchroniser latency, and that a held or disabled trigger leaves the value unchanged.

// File: rtl/tmr_cc_pkg.sv
package tmr_cc_pkg;

    localparam int VAL_W   = 16;
    localparam int CMP_MAX = 100;
    localparam int SYNC_N  = 2;

    typedef enum logic {
        MODE_COMPARE = 1'b0,
        MODE_CAPTURE = 1'b1
    } cc_mode_e;

    // Packed MSB first: mode is the top bit of the configuration field.
    typedef struct packed {
        cc_mode_e mode;
        logic     pol;
        logic     pre;
        logic     en;
    } cc_cfg_t;

    localparam int CFG_W = $bits(cc_cfg_t);

endpackage

// File: rtl/tmr_cc_regs.sv
module tmr_cc_regs
    import tmr_cc_pkg::*;
#(
    parameter int W   = VAL_W,
    parameter int MAX = CMP_MAX
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr,
    input  cc_cfg_t      wcfg,
    input  logic [W-1:0] wval,
    input  logic         upd,
    input  logic         cap_fire,
    input  logic [W-1:0] cap_val,
    output cc_cfg_t      cfg,
    output logic [W-1:0] sw_val,
    output logic [W-1:0] act_val
);

    localparam logic [W-1:0] LIMIT = W'(MAX);

    function automatic logic [W-1:0] clip(input logic [W-1:0] v);
        return (v > LIMIT) ? LIMIT : v;
    endfunction

    logic [W-1:0] wval_sat;
    logic         cap_take;

    assign wval_sat = clip(wval);
    assign cap_take = cap_fire && cfg.en && (cfg.mode == MODE_CAPTURE);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg    <= '0;
            sw_val <= '0;
        end else if (wr) begin
            cfg    <= wcfg;
            sw_val <= wval_sat;
        end else if (cap_take) begin
            sw_val <= cap_val;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_val <= '0;
        end else if (wr && !wcfg.pre) begin
            act_val <= wval_sat;
        end else if (upd && cfg.pre) begin
            act_val <= clip(sw_val);
        end
    end

    p_active_range_r3: assert property (@(posedge clk) disable iff (rst)
        act_val <= LIMIT);

    p_immediate_load_r4: assert property (@(posedge clk) disable iff (rst)
        (wr && !wcfg.pre) |=>
            (act_val == (($past(wval) > LIMIT) ? LIMIT : $past(wval))));

    p_hold_active_r5: assert property (@(posedge clk) disable iff (rst)
        (!wr && !upd) |=> $stable(act_val));

    p_collision_old_r6: assert property (@(posedge clk) disable iff (rst)
        (wr && wcfg.pre && upd && cfg.pre) |=> (act_val == clip($past(sw_val))));

endmodule

// File: rtl/tmr_cc_trigsync.sv
module tmr_cc_trigsync #(
    parameter int STAGES = tmr_cc_pkg::SYNC_N
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise
);

    localparam int CHAIN = STAGES + 1;

    logic [CHAIN-1:0] chain_q;

    genvar g;
    generate
        for (g = 0; g < CHAIN; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[g] <= 1'b0;
                    else     chain_q[g] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain_q[g] <= 1'b0;
                    else     chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign rise = chain_q[STAGES-1] & ~chain_q[STAGES];

    p_single_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);

endmodule

// File: rtl/tmr_cc_compare.sv
module tmr_cc_compare
    import tmr_cc_pkg::*;
#(
    parameter int W = VAL_W
) (
    input  cc_cfg_t      cfg,
    input  logic [W-1:0] act_val,
    input  logic [W-1:0] counter,
    output logic         drive
);

    logic below;

    assign below = (counter < act_val);

    always_comb begin
        if (cfg.en && (cfg.mode == MODE_COMPARE)) drive = below ^ cfg.pol;
        else                                      drive = 1'b0;
    end

endmodule

// File: rtl/tmr_cc_channel.sv
module tmr_cc_channel
    import tmr_cc_pkg::*;
#(
    parameter int VW      = VAL_W,
    parameter int MAXV    = CMP_MAX,
    parameter int NSYNC   = SYNC_N,
    localparam int WORD_W = VW + CFG_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic [VW-1:0]     counter,
    input  logic              update_evt,
    input  logic              trig_in,
    output logic              ch_out
);

    cc_cfg_t       cfg_q;
    cc_cfg_t       wcfg;
    logic [VW-1:0] sw_val;
    logic [VW-1:0] act_val;
    logic          trig_rise;

    assign wcfg = cc_cfg_t'(reg_wdata[WORD_W-1:VW]);

    tmr_cc_trigsync #(.STAGES(NSYNC)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (trig_in),
        .rise     (trig_rise)
    );

    tmr_cc_regs #(.W(VW), .MAX(MAXV)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr       (reg_wr),
        .wcfg     (wcfg),
        .wval     (reg_wdata[VW-1:0]),
        .upd      (update_evt),
        .cap_fire (trig_rise),
        .cap_val  (counter),
        .cfg      (cfg_q),
        .sw_val   (sw_val),
        .act_val  (act_val)
    );

    tmr_cc_compare #(.W(VW)) u_cmp (
        .cfg     (cfg_q),
        .act_val (act_val),
        .counter (counter),
        .drive   (ch_out)
    );

    assign reg_rdata = {cfg_q, sw_val};

    p_idle_low_r8: assert property (@(posedge clk) disable iff (rst)
        (!cfg_q.en || cfg_q.mode == MODE_CAPTURE) |-> !ch_out);

    p_capture_store_r9: assert property (@(posedge clk) disable iff (rst)
        (trig_rise && cfg_q.en && cfg_q.mode == MODE_CAPTURE && !reg_wr)
            |=> (sw_val == $past(counter)));

endmodule

// File: tb/tmr_cc_channel_bench.sv
module tmr_cc_channel_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_wr;
    logic [19:0] reg_wdata;
    logic [19:0] reg_rdata;
    logic [15:0] counter;
    logic        update_evt;
    logic        trig_in;
    logic        ch_out;

    int n_checks = 0;
    int n_errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tmr_cc_channel u_tmr_cc_channel (
        .clk        (clk),
        .rst        (rst),
        .reg_wr     (reg_wr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .counter    (counter),
        .update_evt (update_evt),
        .trig_in    (trig_in),
        .ch_out     (ch_out)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic write_word(input bit en, input bit pre, input bit pol,
                              input bit mode, input int val);
        @(negedge clk);
        reg_wr    = 1'b1;
        reg_wdata = {mode, pol, pre, en, 16'(val)};
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic probe(input string req, input int cnt, input bit exp);
        @(negedge clk);
        counter = 16'(cnt);
        #1;
        check(req, int'(ch_out), int'(exp));
    endtask

    task automatic pulse_update();
        @(negedge clk);
        update_evt = 1'b1;
        @(negedge clk);
        update_evt = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 rdata", int'(reg_rdata), 0);
        check("R1 out", int'(ch_out), 0);
    endtask

    task automatic t_readback();
        write_word(1, 1, 1, 0, 55);
        check("R2 readback", int'(reg_rdata), 32'h70037);
    endtask

    task automatic t_saturate();
        write_word(1, 1, 0, 0, 250);
        check("R3 250", int'(reg_rdata[15:0]), 100);
        write_word(1, 1, 0, 0, 101);
        check("R3 101", int'(reg_rdata[15:0]), 100);
        write_word(1, 1, 0, 0, 100);
        check("R3 100", int'(reg_rdata[15:0]), 100);
        write_word(1, 1, 0, 0, 99);
        check("R3 99", int'(reg_rdata[15:0]), 99);
    endtask

    task automatic t_immediate();
        write_word(1, 0, 0, 0, 40);
        probe("R4 R7 below", 39, 1);
        probe("R4 R7 equal", 40, 0);
        probe("R7 above", 41, 0);
        write_word(1, 0, 1, 0, 40);
        probe("R7 pol below", 39, 0);
        probe("R7 pol equal", 40, 1);
    endtask

    task automatic t_preload();
        write_word(1, 0, 0, 0, 20);
        write_word(1, 1, 0, 0, 70);
        probe("R5 before update", 30, 0);
        pulse_update();
        probe("R5 after update", 30, 1);
        probe("R5 after update top", 70, 0);
    endtask

    task automatic t_collision();
        @(negedge clk);
        reg_wr     = 1'b1;
        reg_wdata  = {1'b0, 1'b0, 1'b1, 1'b1, 16'd10};
        update_evt = 1'b1;
        @(negedge clk);
        reg_wr     = 1'b0;
        update_evt = 1'b0;
        probe("R6 old kept", 50, 1);
        pulse_update();
        probe("R6 new loaded", 50, 0);
        probe("R6 new below", 9, 1);
    endtask

    task automatic t_idle();
        write_word(0, 0, 0, 0, 90);
        probe("R8 disabled", 5, 0);
        write_word(1, 0, 0, 1, 50);
        probe("R8 capture mode", 10, 0);
    endtask

    task automatic t_capture();
        write_word(1, 0, 0, 1, 0);
        @(negedge clk);
        counter = 16'd1234;
        trig_in = 1'b1;
        repeat (2) @(negedge clk);
        check("R9 not yet", int'(reg_rdata[15:0]), 0);
        repeat (2) @(negedge clk);
        check("R9 captured", int'(reg_rdata[15:0]), 1234);
        counter = 16'd999;
        repeat (5) @(negedge clk);
        check("R9 held trigger", int'(reg_rdata[15:0]), 1234);
        trig_in = 1'b0;
        repeat (3) @(negedge clk);
        write_word(0, 0, 0, 1, 5);
        @(negedge clk);
        counter = 16'd777;
        trig_in = 1'b1;
        repeat (5) @(negedge clk);
        check("R9 disabled", int'(reg_rdata[15:0]), 5);
        trig_in = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        rst        = 1'b1;
        reg_wr     = 1'b0;
        reg_wdata  = '0;
        counter    = '0;
        update_evt = 1'b0;
        trig_in    = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        t_reset();
        t_readback();
        t_saturate();
        t_immediate();
        t_preload();
        t_collision();
        t_idle();
        t_capture();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule